// File: doc/BRIEF.md
# External Interrupt Request Combiner

This block forms the single external interrupt request that goes to a CPU core. It has two kinds of source. One is a dedicated request pin that is active low. The other is a group of port input pins that are active high. A static enable decides whether the port pins are merged into the request path. All sources are synchronized and then folded into one shared trigger. The port inputs are inverted and ORed with the active-low pin, so a single trigger level covers every source.

A second static select sets the triggering mode. In edge-only mode, the pending request is set only when the shared trigger changes from inactive to active. In edge-and-level mode, the request is also set whenever the shared trigger is active.

The pending flag stays set until the core pulses its acknowledge for one cycle. Because every source drives one trigger, a source that stays asserted hides new edges on all the other sources. The configuration inputs are meant to change only while reset is held.

Top module: `irq_combiner`

## Requirements
- R1: While reset is low and in the cycles just after it, `irq_pending` and `trig_level` are 0. This holds when no source is asserted.
- R2: `trig_level` is 1 exactly when the request pin is low, or `cfg_port_en` is 1 and any `port_pin` bit is 1. Inputs pass two flops before they reach `trig_level`, so it reflects the pin values from two clock edges earlier.
- R3: In edge-only mode (`cfg_level_mode`=0), a falling edge on `irq_n_pin` sets `irq_pending` at the third rising clock edge after the pin changes. `irq_pending` then stays at 1 until `ack`.
- R4: In edge-only mode with `cfg_port_en`=1, a rising edge on one port bit sets `irq_pending`, provided the request pin is high and the other port bits are low.
- R5: With `cfg_port_en`=0, the port pins change neither `trig_level` nor `irq_pending`.
- R6: In edge-only mode, suppose one source stays asserted. This means a port bit held at 1 or the request pin held at 0. Pulses on the other sources then leave `irq_pending` at 0 after the request was acknowledged.
- R7: In edge-and-level mode (`cfg_level_mode`=1), an active `trig_level` sets `irq_pending` at the next clock edge. After an `ack` it sets again if the trigger is still active.
- R8: A one-cycle `ack` clears `irq_pending` at that clock edge. The clear takes priority over any set in the same cycle. In edge-only mode, the flag stays clear while the trigger remains active.
- R9: Suppose a source is asserted during reset and stays asserted. It raises `irq_pending` after reset only in edge-and-level mode. In edge-only mode it does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_port_en | input | 1 | Static: 1 merges the port pins into the trigger |
| cfg_level_mode | input | 1 | Static: 0 edge-only, 1 edge-and-level |
| irq_n_pin | input | 1 | Dedicated request pin, active low, asynchronous |
| port_pin | input | NSRC (4) | Port request pins, active high, asynchronous |
| ack | input | 1 | One-cycle acknowledge from the core |
| irq_pending | output | 1 | Latched request to the core |
| trig_level | output | 1 | Synchronized combined trigger, 1 = active |

## Verification
The assertions check four rules on every cycle:
- the trigger level matches the pin values from two edges earlier;
- a pending flag persists until it is acknowledged;
- an acknowledge always clears the flag;
- in level mode, an active trigger always sets the flag.

Some behaviour depends on history across many cycles, and only the bench scenarios show it. This covers the three-edge latency of an edge request, masking by a held source, the asserted-at-reset case in each mode, and the full sweep of pin patterns against both configuration inputs.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NSRC = 4,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_port_en,
  input  logic            cfg_level_mode,
  input  logic            irq_n_pin,
  input  logic [NSRC-1:0] port_pin,
  input  logic            ack,
  output logic            irq_pending,
  output logic            trig_level
);
  localparam int CW = $clog2(SYNC + 2);
  localparam logic [CW-1:0] WARM_END = CW'(SYNC + 1);

  logic [SYNC-1:0]           irq_sync;
  logic [SYNC-1:0][NSRC-1:0] port_sync;
  logic [CW-1:0]             warm;
  logic                      trig_prev_n;
  logic                      trig_n;
  logic                      fall;
  logic                      set_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sync  <= '1;
      port_sync <= '0;
    end else begin
      irq_sync  <= {irq_sync[SYNC-2:0], irq_n_pin};
      port_sync <= {port_sync[SYNC-2:0], port_pin};
    end
  end

  assign trig_n     = irq_sync[SYNC-1] & ~(cfg_port_en & (|port_sync[SYNC-1]));
  assign trig_level = ~trig_n;

  // edges are ignored until the synchronizers hold real pin values
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm        <= '0;
      trig_prev_n <= 1'b1;
    end else begin
      if (warm != WARM_END) warm <= warm + 1'b1;
      trig_prev_n <= trig_n;
    end
  end

  assign fall    = (warm == WARM_END) & trig_prev_n & ~trig_n;
  assign set_req = fall | (cfg_level_mode & ~trig_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_pending <= 1'b0;
    else if (ack) irq_pending <= 1'b0;
    else          irq_pending <= irq_pending | set_req;
  end
endmodule

module irq_combiner_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_port_en,
  input logic            cfg_level_mode,
  input logic            irq_n_pin,
  input logic [NSRC-1:0] port_pin,
  input logic            ack,
  input logic            irq_pending,
  input logic            trig_level
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  trig_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (trig_level == (!$past(irq_n_pin, 2) | (cfg_port_en & (|$past(port_pin, 2))))));

  // R3
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !ack) |=> irq_pending);

  // R7
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level_mode && trig_level && !ack) |=> irq_pending);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_pending);
endmodule

bind irq_combiner irq_combiner_chk #(.NSRC(NSRC)) i_chk (.*);

// File: tb/test_irq_combiner.sv
`timescale 1ns/1ps
module test_irq_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_port_en = 1'b0;
  logic       cfg_level_mode = 1'b0;
  logic       irq_n_pin = 1'b1;
  logic [3:0] port_pin = '0;
  logic       ack = 1'b0;
  logic       irq_pending;
  logic       trig_level;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_combiner i_irq_combiner (
    .clk(clk), .rst_n(rst_n), .cfg_port_en(cfg_port_en), .cfg_level_mode(cfg_level_mode),
    .irq_n_pin(irq_n_pin), .port_pin(port_pin), .ack(ack),
    .irq_pending(irq_pending), .trig_level(trig_level)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic en, input logic lvl);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_port_en = en;
    cfg_level_mode = lvl;
    tick(2);
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic exp_t;

    // R1: reset state
    tick(1);
    check(irq_pending, 1'b0, "R1 pending in reset");
    check(trig_level, 1'b0, "R1 trig in reset");
    do_reset(1'b1, 1'b0);
    check(irq_pending, 1'b0, "R1 pending after reset");
    check(trig_level, 1'b0, "R1 trig after reset");

    // R2 R4 R5 R7 R8: sweep of every pin pattern under every configuration
    for (int cfg = 0; cfg < 4; cfg++) begin
      do_reset(cfg[0], cfg[1]);
      for (int pat = 0; pat < 32; pat++) begin
        exp_t = !pat[4] | (cfg[0] & (|pat[3:0]));
        irq_n_pin = pat[4];
        port_pin = pat[3:0];
        tick(4);
        check(trig_level, exp_t, "R2/R5 trig level");
        check(irq_pending, exp_t, "R4/R5 pending from idle");
        pulse_ack();
        tick(2);
        check(irq_pending, exp_t & cfg[1], "R7/R8 pending after ack");
        irq_n_pin = 1'b1;
        port_pin = '0;
        tick(4);
        pulse_ack();
        tick(2);
        check(irq_pending, 1'b0, "R8 clear after idle ack");
      end
    end

    // R3: exact latency of a request-pin edge
    do_reset(1'b0, 1'b0);
    irq_n_pin = 1'b0;
    tick(2);
    check(irq_pending, 1'b0, "R3 not yet after two edges");
    tick(1);
    check(irq_pending, 1'b1, "R3 set after third edge");
    irq_n_pin = 1'b1;
    tick(6);
    check(irq_pending, 1'b1, "R3 held until ack");
    pulse_ack();
    check(irq_pending, 1'b0, "R8 cleared by ack");

    // R6: held port bit masks other port edges
    do_reset(1'b1, 1'b0);
    port_pin = 4'b0001;
    tick(4);
    pulse_ack();
    tick(2);
    port_pin = 4'b0011;
    tick(5);
    port_pin = 4'b0001;
    tick(5);
    check(irq_pending, 1'b0, "R6 port edge masked by held port");

    // R6: held request pin masks port edges
    port_pin = '0;
    irq_n_pin = 1'b0;
    tick(4);
    pulse_ack();
    tick(2);
    port_pin = 4'b0100;
    tick(5);
    port_pin = 4'b0000;
    tick(5);
    check(irq_pending, 1'b0, "R6 port edge masked by low pin");

    // R4: once released, a new port edge is seen
    irq_n_pin = 1'b1;
    tick(4);
    port_pin = 4'b1000;
    tick(4);
    check(irq_pending, 1'b1, "R4 edge after release");
    port_pin = '0;

    // R5: disabled port pulse
    do_reset(1'b0, 1'b1);
    port_pin = 4'b1111;
    tick(5);
    check(trig_level, 1'b0, "R5 trig with port disabled");
    check(irq_pending, 1'b0, "R5 pending with port disabled");
    port_pin = '0;

    // R9: source asserted through reset
    irq_n_pin = 1'b0;
    do_reset(1'b1, 1'b0);
    tick(3);
    check(trig_level, 1'b1, "R9 trig active edge mode");
    check(irq_pending, 1'b0, "R9 no request edge mode");
    do_reset(1'b1, 1'b1);
    tick(3);
    check(irq_pending, 1'b1, "R9 request level mode");
    irq_n_pin = 1'b1;
    tick(2);

    finish_run();
  end
endmodule